// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block turns the synchronized input values of an 8-pin general purpose port into interrupt requests. Each pin can be set to watch for a level or for an edge. A polarity bit picks high or low level, or rising or falling edge. A separate bit makes an edge-mode pin respond to both edges. Edge events are caught in a sticky status bit that software clears by writing a one to it. A level-mode status bit follows the pin without being held.

The configuration, enable, status and clear registers all sit on the same register bus as the port's data and direction registers, so the register offsets are fixed. The raw status is ANDed with a per-pin enable to form the masked status. The OR of the masked bits drives a single registered interrupt line. Software picks which pin to service by reading the masked status.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset, the sense, both-edge, polarity and enable registers read 0, the raw and masked status read 0, and `irq_out` is 0.
- R2: The registers at these offsets can be written and read back: sense 0x404, both-edge 0x408, polarity 0x40C and enable 0x410. In every register, bit i belongs to pin i.
- R3: A pin whose sense bit is 1 is in level mode. Its raw status bit (offset 0x414) equals the pin when its polarity bit is 1, and the inverted pin when its polarity bit is 0. The bit is not held after the level goes away, and a clear write does not change it.
- R4: A pin whose sense bit is 0 and both-edge bit is 0 is in edge mode. It sets its raw status bit on a 0-to-1 change when polarity is 1, and on a 1-to-0 change when polarity is 0. The opposite edge does not set the bit.
- R5: An edge-mode pin whose both-edge bit is 1 sets its raw status bit on any change of the pin, whatever its polarity bit holds.
- R6: An edge-set status bit stays set until a write to the clear register (offset 0x41C) carries a 1 in that bit position. Bits written as 0 leave the other status bits unchanged. The clear register reads as 0.
- R7: The masked status (offset 0x418) reads as the raw status ANDed with the enable register.
- R8: `irq_out` is the OR of the masked status bits, registered once: it reflects the masked status of the previous clock cycle. With the enable register at 0, `irq_out` stays 0.
- R9: Writes to the raw and masked status offsets have no effect on what they read.
- R10: When an edge arrives in the same cycle as a clear write for the same bit, the edge wins and the bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Synchronized pin values |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Each of the eight pins is given a different mix of sense, both-edge and polarity. A long sequence of pin values then covers every transition in every mode at once. A design that swapped polarity meanings, or let the polarity bit still apply when both edges are selected, would set the wrong raw bits at once. Clear writes are mixed into the sequence, sometimes in the same cycle as a new edge. A design where the clear takes priority would lose that edge, and a clear that reached level-mode bits would drop a pin that is still active. The single register on `irq_out` is checked cycle by cycle. A combinational output, or one delayed twice, would be off by a cycle. Writes to the read-only status offsets are checked to change nothing.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 12;

  // Offsets shared with the port's register decode
  localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_POL   = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_EN    = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;

  // Edge qualifier for one pin: both-edge overrides polarity
  function automatic logic edge_event(input logic rise, input logic fall,
                                      input logic pol, input logic both);
    if (both) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Level qualifier for one pin
  function automatic logic level_active(input logic pin, input logic pol);
    return pol ? pin : ~pin;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  sense_q,
  output logic [NPINS-1:0]  both_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  en_q,
  output logic [NPINS-1:0]  clr_mask
);
  logic wr_sense, wr_both, wr_pol, wr_en;

  assign wr_sense = reg_wr && (reg_addr == OFS_SENSE);
  assign wr_both  = reg_wr && (reg_addr == OFS_BOTH);
  assign wr_pol   = reg_wr && (reg_addr == OFS_POL);
  assign wr_en    = reg_wr && (reg_addr == OFS_EN);

  // One-cycle clear pulse, not stored
  assign clr_mask = (reg_wr && (reg_addr == OFS_CLR)) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else begin
      if (wr_sense) sense_q <= reg_wdata;
      if (wr_both)  both_q  <= reg_wdata;
      if (wr_pol)   pol_q   <= reg_wdata;
      if (wr_en)    en_q    <= reg_wdata;
    end
  end
endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] sense,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] edge_hit,
  output logic [NPINS-1:0] lat_q,
  output logic [NPINS-1:0] raw_stat,
  output logic             prev_vld
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] lat_nxt;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl;
    assign rise = pin_in[i] & ~prev_q[i];
    assign fall = ~pin_in[i] & prev_q[i];
    assign lvl  = level_active(pin_in[i], pol[i]);
    assign edge_hit[i] = prev_vld & ~sense[i] &
                         edge_event(rise, fall, pol[i], both[i]);
    // A new edge outranks a clear in the same cycle
    assign lat_nxt[i]  = (lat_q[i] & ~clr_mask[i]) | edge_hit[i];
    assign raw_stat[i] = sense[i] ? lvl : lat_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      prev_vld <= 1'b0;
      lat_q    <= '0;
    end else begin
      prev_q   <= pin_in;
      prev_vld <= 1'b1;
      lat_q    <= lat_nxt;
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw_stat,
  input  logic [NPINS-1:0] en_q,
  output logic [NPINS-1:0] masked,
  output logic             irq_out
);
  assign masked = raw_stat & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |masked;
  end
endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic              irq_out
);
  logic [NPINS-1:0] sense_q, both_q, pol_q, en_q, clr_mask;
  logic [NPINS-1:0] edge_hit, lat_q, raw_stat, masked;
  logic             prev_vld;

  irq_cfg_regs #(.NPINS(NPINS)) cfg_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sense_q(sense_q), .both_q(both_q),
    .pol_q(pol_q), .en_q(en_q), .clr_mask(clr_mask)
  );

  irq_detect #(.NPINS(NPINS)) det_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sense(sense_q),
    .both(both_q), .pol(pol_q), .clr_mask(clr_mask), .edge_hit(edge_hit),
    .lat_q(lat_q), .raw_stat(raw_stat), .prev_vld(prev_vld)
  );

  irq_combine #(.NPINS(NPINS)) cmb_i (
    .clk(clk), .rst_n(rst_n), .raw_stat(raw_stat), .en_q(en_q),
    .masked(masked), .irq_out(irq_out)
  );

  always_comb begin
    case (reg_addr)
      OFS_SENSE: reg_rdata = sense_q;
      OFS_BOTH:  reg_rdata = both_q;
      OFS_POL:   reg_rdata = pol_q;
      OFS_EN:    reg_rdata = en_q;
      OFS_RAW:   reg_rdata = raw_stat;
      OFS_MASK:  reg_rdata = masked;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPINS-1:0]  pin_in,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NPINS-1:0]  reg_rdata,
  input logic              irq_out,
  input logic [NPINS-1:0]  sense_q,
  input logic [NPINS-1:0]  both_q,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  clr_mask,
  input logic [NPINS-1:0]  edge_hit,
  input logic [NPINS-1:0]  lat_q,
  input logic [NPINS-1:0]  raw_stat,
  input logic              prev_vld
);
  // R8
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |($past(raw_stat) & $past(en_q)));

  // R8
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) == '0) |-> !irq_out);

  // R6
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lat_q) & ~$past(clr_mask) & ~lat_q) == '0));

  // R4
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & ~(pin_in ^ $past(pin_in))) == '0));

  // R5
  both_edge_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_vld |-> ((~sense_q & both_q & (pin_in ^ $past(pin_in)) & ~edge_hit) == '0));

  // R6
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_CLR) |-> (reg_rdata == '0));
endmodule

bind gpio_irq_detector gpio_irq_checker #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq_out(irq_out), .sense_q(sense_q),
  .both_q(both_q), .en_q(en_q), .clr_mask(clr_mask), .edge_hit(edge_hit),
  .lat_q(lat_q), .raw_stat(raw_stat), .prev_vld(prev_vld)
);

// File: tb/gpio_irq_detector_tb_top.sv
module gpio_irq_detector_tb_top;
  localparam logic [11:0] A_SENSE = 12'h404;
  localparam logic [11:0] A_BOTH  = 12'h408;
  localparam logic [11:0] A_POL   = 12'h40C;
  localparam logic [11:0] A_EN    = 12'h410;
  localparam logic [11:0] A_RAW   = 12'h414;
  localparam logic [11:0] A_MASK  = 12'h418;
  localparam logic [11:0] A_CLR   = 12'h41C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic       reg_wr = 1'b0;
  logic [11:0] reg_addr = 12'h000;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_out;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_irq_detector dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  // Bench model state
  logic [7:0] m_sense, m_both, m_pol, m_en, m_prev, m_lat;

  task automatic sweep_step(input logic [7:0] v, input logic do_clr, input logic [7:0] clr);
    logic [7:0] exp_raw;
    @(negedge clk);
    pin_in = v;
    if (do_clr) begin reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = clr; end
    @(posedge clk); #1;
    reg_wr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic up, dn, hit;
      up = v[i] && !m_prev[i];
      dn = !v[i] && m_prev[i];
      hit = 1'b0;
      if (!m_sense[i]) begin
        if (m_both[i])     hit = up || dn;
        else if (m_pol[i]) hit = up;
        else               hit = dn;
      end
      if (do_clr && clr[i]) m_lat[i] = 1'b0;
      if (hit) m_lat[i] = 1'b1;
      if (m_sense[i]) exp_raw[i] = (v[i] == m_pol[i]);
      else            exp_raw[i] = m_lat[i];
    end
    m_prev = v;
    rd("R3 R4 R5 R6 R10 raw", A_RAW, exp_raw);
    rd("R7 masked", A_MASK, exp_raw & m_en);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd("R1 sense", A_SENSE, 8'h00);
    rd("R1 both", A_BOTH, 8'h00);
    rd("R1 pol", A_POL, 8'h00);
    rd("R1 en", A_EN, 8'h00);
    rd("R1 raw", A_RAW, 8'h00);
    rd("R1 masked", A_MASK, 8'h00);
    chk("R1 irq", {7'b0, irq_out}, 8'h00);

    // R2 readback
    wr(A_SENSE, 8'h5A); wr(A_BOTH, 8'hC3); wr(A_POL, 8'h96); wr(A_EN, 8'h21);
    rd("R2 sense", A_SENSE, 8'h5A);
    rd("R2 both", A_BOTH, 8'hC3);
    rd("R2 pol", A_POL, 8'h96);
    rd("R2 en", A_EN, 8'h21);
    rd("R6 clear reads 0", A_CLR, 8'h00);

    // Sweep: each pin gets its own mode mix
    m_sense = 8'hF0; m_both = 8'hCC; m_pol = 8'hAA; m_en = 8'h69;
    wr(A_SENSE, m_sense); wr(A_BOTH, m_both); wr(A_POL, m_pol); wr(A_EN, m_en);
    wr(A_CLR, 8'hFF);
    m_prev = 8'h00; m_lat = 8'h00;
    for (int s = 0; s < 96; s++) begin
      logic [7:0] v, c;
      v = 8'((s * 167) ^ (s >> 1));
      c = 8'(s * 53 + 7);
      sweep_step(v, (s % 5) == 3, c);
    end

    // R9 read-only status
    wr(A_SENSE, 8'hFF); wr(A_POL, 8'hFF); wr(A_EN, 8'h00);
    @(negedge clk); pin_in = 8'hFF;
    @(posedge clk); #1;
    wr(A_RAW, 8'h00);
    rd("R9 raw unchanged", A_RAW, 8'hFF);
    // R3 clear has no effect on level bits
    wr(A_CLR, 8'hFF);
    rd("R3 level survives clear", A_RAW, 8'hFF);
    @(posedge clk); #1;
    rd("R8 masked with en 0", A_MASK, 8'h00);
    chk("R8 irq with en 0", {7'b0, irq_out}, 8'h00);
    wr(A_EN, 8'h0F);
    wr(A_MASK, 8'h00);
    rd("R9 masked unchanged", A_MASK, 8'h0F);
    wr(A_EN, 8'h00);
    @(posedge clk); #1;

    // R8 registered combine: single level pin
    wr(A_SENSE, 8'h08); wr(A_POL, 8'h08);
    @(negedge clk); pin_in = 8'h08;
    @(posedge clk); #1;
    wr(A_EN, 8'h08);
    chk("R8 irq one cycle after enable", {7'b0, irq_out}, 8'h00);
    @(posedge clk); #1;
    chk("R8 irq asserted", {7'b0, irq_out}, 8'h01);
    wr(A_EN, 8'h00);
    chk("R8 irq still from prior cycle", {7'b0, irq_out}, 8'h01);
    @(posedge clk); #1;
    chk("R8 irq cleared by enable 0", {7'b0, irq_out}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule